// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block turns virtual addresses into physical addresses for a small processor that uses 4 KB pages and refills its translations in software. Each cycle it can take one request. A request carries a virtual address, an access kind (read, write or execute) and the identifier of the address space that is currently running. The 64 stored translations are all compared against the request at once. One clock edge later the block reports one of three results: a normal completion that carries the physical address, a miss, or a protection fault.

The block never walks page tables. When a request misses, the miss flag tells the processor to trap. The trap handler then writes the missing translation into a slot it chooses, using the fill port. A single flush input drops every translation in one cycle. Each entry carries its own address-space identifier, so translations that belong to different processes can sit in the buffer together. The permission check runs in parallel with the tag compare, which means a request can find its translation and still be refused.

Top module: `xlat_cache`

## Requirements
- R1: After reset every output is low and every entry is invalid, so the first request that follows reset is reported as a miss.
- R2: A request is taken at a clock edge. At the next edge its outcome appears on the outputs. An entry matches when it is valid, its stored page number equals bits 31:12 of the request address, and its stored identifier equals the request identifier. An entry in any slot can match, including slots 0 and 63.
- R3: On a normal completion the physical address is the matching entry's 20-bit page number placed above bits 11:0 of the virtual address, which pass through unchanged.
- R4: An entry whose identifier differs from the request identifier never matches, even when the page numbers are equal.
- R5: Access kind codes are 2'b00 read, 2'b01 write, 2'b10 execute and 2'b11 reserved. The fill permission field uses bit 0 for read, bit 1 for write and bit 2 for execute. Code 2'b11 is permitted by no bit. When a request matches but its permission bit is clear, the block raises the fault flag, keeps the completion flag low and drives the physical address to zero.
- R6: When no entry matches, the block raises the miss flag and drives the physical address to zero.
- R7: A fill with the valid bit set writes page number, frame number, identifier and permissions into the chosen 6-bit slot at the next clock edge. A request in the same cycle as the fill sees the old contents.
- R8: A fill with the valid bit clear invalidates the chosen slot.
- R9: The flush input clears every valid bit at the next edge. When a fill arrives in the same cycle as a flush, the flush wins and the fill is dropped.
- R10: When more than one entry matches, the lowest-numbered slot supplies the translation and the multi-match flag is raised.
- R11: At most one of completion, miss and fault is high at any time. All three are low one cycle after a cycle with no request, and exactly one is high one cycle after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A lookup request is present this cycle |
| req_vaddr | input | 32 | Virtual address of the request |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| req_asid | input | 8 | Address-space identifier of the requester |
| fill_en | input | 1 | Software write into one slot |
| fill_vld | input | 1 | Valid bit written with the fill |
| fill_slot | input | 6 | Slot chosen by software |
| fill_vpn | input | 20 | Virtual page number for the slot |
| fill_ppn | input | 20 | Physical page number for the slot |
| fill_asid | input | 8 | Identifier for the slot |
| fill_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| flush_all | input | 1 | Invalidate every slot |
| rsp_paddr | output | 32 | Physical address on a normal completion, zero otherwise |
| rsp_hit | output | 1 | Translation found and access permitted |
| rsp_miss | output | 1 | No translation found; software refill is needed |
| rsp_fault | output | 1 | Translation found but the access is not permitted |
| rsp_multi | output | 1 | More than one slot matched the request |

## Verification
A single request can only meet several matching slots if software has first loaded duplicate translations, because no normal refill sequence produces them. The stimulus therefore loads the same page and identifier into slots 10 and 20, giving each a different frame. The check then expects the frame of slot 10 together with the multi-match flag. The race cases need the same kind of deliberate setup. In one, a fill and a lookup of the same page arrive together. In the other, a flush and a fill arrive together. Both are driven in one cycle, and the affected pages are looked up on the cycles that follow, so the outcome is observed at the ports.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam int PERM_W     = 3;
  localparam int PERM_RD_B  = 0;
  localparam int PERM_WR_B  = 1;
  localparam int PERM_EX_B  = 2;

  // Picks the permission bit that governs an access kind.
  function automatic logic access_allowed(input logic [PERM_W-1:0] perm,
                                          input acc_kind_e kind);
    logic ok;
    case (kind)
      ACC_READ:  ok = perm[PERM_RD_B];
      ACC_WRITE: ok = perm[PERM_WR_B];
      ACC_EXEC:  ok = perm[PERM_EX_B];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic                                   wr_vld,
  input  logic [IDX_W-1:0]                       wr_slot,
  input  logic [VPN_W-1:0]                       wr_vpn,
  input  logic [PPN_W-1:0]                       wr_ppn,
  input  logic [ASID_W-1:0]                      wr_asid,
  input  logic [xlat_pkg::PERM_W-1:0]            wr_perm,
  input  logic                                   clr_all,
  output logic [ENTRIES-1:0]                     ent_valid,
  output logic [ENTRIES-1:0][VPN_W-1:0]          ent_vpn,
  output logic [ENTRIES-1:0][PPN_W-1:0]          ent_ppn,
  output logic [ENTRIES-1:0][ASID_W-1:0]         ent_asid,
  output logic [ENTRIES-1:0][xlat_pkg::PERM_W-1:0] ent_perm
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic slot_sel;
    assign slot_sel = wr_en && (wr_slot == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
      end else if (clr_all) begin
        ent_valid[g] <= 1'b0;
      end else if (slot_sel) begin
        ent_valid[g] <= wr_vld;
      end
    end

    always_ff @(posedge clk) begin
      if (slot_sel && !clr_all) begin
        ent_vpn[g]  <= wr_vpn;
        ent_ppn[g]  <= wr_ppn;
        ent_asid[g] <= wr_asid;
        ent_perm[g] <= wr_perm;
      end
    end
  end

endmodule

// File: rtl/xlat_cam_match.sv
module xlat_cam_match #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  output logic [ENTRIES-1:0]             match_vec,
  output logic [ENTRIES-1:0]             grant_vec,
  output logic [IDX_W-1:0]               grant_idx,
  output logic                           any_match,
  output logic                           multi_match
);

  // Keeps only the lowest set bit.
  function automatic logic [ENTRIES-1:0] lowest_bit(input logic [ENTRIES-1:0] v);
    return v & (~v + ENTRIES'(1));
  endfunction

  // True when two or more bits are set.
  function automatic logic several_bits(input logic [ENTRIES-1:0] v);
    return (v & (v - ENTRIES'(1))) != '0;
  endfunction

  // Encodes a one-hot vector into its index.
  function automatic logic [IDX_W-1:0] onehot_index(input logic [ENTRIES-1:0] oh);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (oh[i]) idx = idx | IDX_W'(i);
    end
    return idx;
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = ent_valid[g] &&
                          (ent_vpn[g] == key_vpn) &&
                          (ent_asid[g] == key_asid);
  end

  assign grant_vec   = lowest_bit(match_vec);
  assign grant_idx   = onehot_index(grant_vec);
  assign any_match   = |match_vec;
  assign multi_match = several_bits(match_vec);

endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check (
  input  logic [xlat_pkg::PERM_W-1:0] perm,
  input  logic [1:0]                  kind,
  output logic                        allowed
);

  assign allowed = xlat_pkg::access_allowed(perm, xlat_pkg::acc_kind_e'(kind));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20,
  parameter int ASID_W    = 8,
  parameter int ENTRIES   = 64,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PA_W     = PPN_W + PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [VA_W-1:0]             req_vaddr,
  input  logic [1:0]                  req_kind,
  input  logic [ASID_W-1:0]           req_asid,
  input  logic                        fill_en,
  input  logic                        fill_vld,
  input  logic [IDX_W-1:0]            fill_slot,
  input  logic [VPN_W-1:0]            fill_vpn,
  input  logic [PPN_W-1:0]            fill_ppn,
  input  logic [ASID_W-1:0]           fill_asid,
  input  logic [xlat_pkg::PERM_W-1:0] fill_perm,
  input  logic                        flush_all,
  output logic [PA_W-1:0]             rsp_paddr,
  output logic                        rsp_hit,
  output logic                        rsp_miss,
  output logic                        rsp_fault,
  output logic                        rsp_multi
);

  // Named internal events, visible to the bound checker.
  logic [ENTRIES-1:0]                      entry_valid_vec;
  logic [ENTRIES-1:0][VPN_W-1:0]           entry_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0]           entry_ppn;
  logic [ENTRIES-1:0][ASID_W-1:0]          entry_asid;
  logic [ENTRIES-1:0][xlat_pkg::PERM_W-1:0] entry_perm;
  logic [ENTRIES-1:0]                      lookup_match_vec;
  logic [ENTRIES-1:0]                      lookup_grant_vec;
  logic [IDX_W-1:0]                        lookup_idx;
  logic                                    lookup_any;
  logic                                    lookup_multi;
  logic                                    lookup_perm_ok;
  logic [VPN_W-1:0]                        req_vpn;
  logic [PAGE_BITS-1:0]                    req_offset;
  logic [PPN_W-1:0]                        sel_ppn;
  logic [xlat_pkg::PERM_W-1:0]             sel_perm;
  logic                                    next_hit;
  logic                                    next_miss;
  logic                                    next_fault;

  // Joins a frame number with the untranslated page offset.
  function automatic logic [PA_W-1:0] form_paddr(input logic [PPN_W-1:0] ppn,
                                                 input logic [PAGE_BITS-1:0] off);
    return {ppn, off};
  endfunction

  assign req_vpn    = req_vaddr[VA_W-1:PAGE_BITS];
  assign req_offset = req_vaddr[PAGE_BITS-1:0];

  xlat_entry_store #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .ASID_W  (ASID_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (fill_en),
    .wr_vld    (fill_vld),
    .wr_slot   (fill_slot),
    .wr_vpn    (fill_vpn),
    .wr_ppn    (fill_ppn),
    .wr_asid   (fill_asid),
    .wr_perm   (fill_perm),
    .clr_all   (flush_all),
    .ent_valid (entry_valid_vec),
    .ent_vpn   (entry_vpn),
    .ent_ppn   (entry_ppn),
    .ent_asid  (entry_asid),
    .ent_perm  (entry_perm)
  );

  xlat_cam_match #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .ASID_W  (ASID_W)
  ) u_match (
    .key_vpn     (req_vpn),
    .key_asid    (req_asid),
    .ent_valid   (entry_valid_vec),
    .ent_vpn     (entry_vpn),
    .ent_asid    (entry_asid),
    .match_vec   (lookup_match_vec),
    .grant_vec   (lookup_grant_vec),
    .grant_idx   (lookup_idx),
    .any_match   (lookup_any),
    .multi_match (lookup_multi)
  );

  assign sel_ppn  = entry_ppn[lookup_idx];
  assign sel_perm = entry_perm[lookup_idx];

  xlat_perm_check u_perm (
    .perm    (sel_perm),
    .kind    (req_kind),
    .allowed (lookup_perm_ok)
  );

  assign next_hit   = req_valid &&  lookup_any &&  lookup_perm_ok;
  assign next_fault = req_valid &&  lookup_any && !lookup_perm_ok;
  assign next_miss  = req_valid && !lookup_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_hit   <= next_hit;
      rsp_miss  <= next_miss;
      rsp_fault <= next_fault;
      rsp_multi <= req_valid && lookup_multi;
      rsp_paddr <= next_hit ? form_paddr(sel_ppn, req_offset) : '0;
    end
  end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES   = 64,
  parameter int PAGE_BITS = 12,
  parameter int PA_W      = 32,
  parameter int VA_W      = 32,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [VA_W-1:0]    req_vaddr,
  input logic               fill_en,
  input logic               fill_vld,
  input logic [IDX_W-1:0]   fill_slot,
  input logic               flush_all,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_fault,
  input logic               rsp_multi,
  input logic [ENTRIES-1:0] entry_valid_vec,
  input logic [ENTRIES-1:0] lookup_match_vec,
  input logic [ENTRIES-1:0] lookup_grant_vec
);

  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rsp_hit, rsp_miss, rsp_fault}) <= 1);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(rsp_hit || rsp_miss || rsp_fault));

  p_req_answered_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit || rsp_miss || rsp_fault));

  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));

  p_no_addr_unless_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_paddr == '0);

  p_fill_sets_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_vld && !flush_all) |=> entry_valid_vec[$past(fill_slot)]);

  p_fill_clears_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_vld && !flush_all) |=> !entry_valid_vec[$past(fill_slot)]);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> entry_valid_vec == '0);

  p_grant_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lookup_grant_vec) && ((lookup_grant_vec & ~lookup_match_vec) == '0));

  p_multi_has_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> (rsp_hit || rsp_fault));

endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES   (ENTRIES),
  .PAGE_BITS (PAGE_BITS),
  .PA_W      (PA_W),
  .VA_W      (VA_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_vaddr        (req_vaddr),
  .fill_en          (fill_en),
  .fill_vld         (fill_vld),
  .fill_slot        (fill_slot),
  .flush_all        (flush_all),
  .rsp_paddr        (rsp_paddr),
  .rsp_hit          (rsp_hit),
  .rsp_miss         (rsp_miss),
  .rsp_fault        (rsp_fault),
  .rsp_multi        (rsp_multi),
  .entry_valid_vec  (entry_valid_vec),
  .lookup_match_vec (lookup_match_vec),
  .lookup_grant_vec (lookup_grant_vec)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_asid = '0;
  logic        fill_en = 1'b0;
  logic        fill_vld = 1'b0;
  logic [5:0]  fill_slot = '0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic [7:0]  fill_asid = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush_all = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_hit, rsp_miss, rsp_fault, rsp_multi;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind), .req_asid(req_asid),
    .fill_en(fill_en), .fill_vld(fill_vld), .fill_slot(fill_slot), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_asid(fill_asid), .fill_perm(fill_perm), .flush_all(flush_all),
    .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_multi(rsp_multi)
  );

  // flag order in vectors: {hit, miss, fault}
  localparam logic [2:0] F_HIT = 3'b100, F_MISS = 3'b010, F_FLT = 3'b001;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic [7:0]  asid;
    logic [2:0]  flg;
    logic [31:0] pa;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VTBL [NVEC] = '{
    '{32'h00010ABC, 2'b00, 8'd1, F_HIT,  32'hAAAAAABC}, // R2 R3 slot 0 read
    '{32'h00010ABC, 2'b01, 8'd1, F_FLT,  32'h0},        // R5 write to read-only
    '{32'h00010123, 2'b10, 8'd1, F_FLT,  32'h0},        // R5 exec to read-only
    '{32'h00010FFF, 2'b00, 8'd2, F_MISS, 32'h0},        // R4 wrong identifier
    '{32'h00020000, 2'b01, 8'd1, F_HIT,  32'h12345000}, // R2 write permitted
    '{32'h00020001, 2'b10, 8'd1, F_FLT,  32'h0},        // R5 exec not permitted
    '{32'hFFFFF7FF, 2'b10, 8'd2, F_HIT,  32'h000017FF}, // R2 R3 slot 63
    '{32'hFFFFF7FF, 2'b00, 8'd2, F_FLT,  32'h0},        // R5 read of exec-only
    '{32'h00040000, 2'b00, 8'd1, F_MISS, 32'h0},        // R6 absent page
    '{32'h00020ABC, 2'b11, 8'd1, F_FLT,  32'h0}         // R5 reserved kind
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [5:0] slot, input logic vld, input logic [19:0] vpn,
                      input logic [19:0] ppn, input logic [7:0] asid, input logic [2:0] perm);
    fill_en = 1'b1; fill_vld = vld; fill_slot = slot; fill_vpn = vpn;
    fill_ppn = ppn; fill_asid = asid; fill_perm = perm;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // Drives a request and returns at the following falling edge, where outputs are valid.
  task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic [7:0] asid);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [2:0] flags();
    return {rsp_hit, rsp_miss, rsp_fault};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outputs after reset", {27'd0, flags(), rsp_multi, rsp_paddr}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    lookup(32'h00000000, 2'b00, 8'd0);
    chk("R1 first lookup misses", {61'd0, flags()}, {61'd0, F_MISS});

    // R11: idle cycle
    @(negedge clk);
    chk("R11 idle flags low", {61'd0, flags()}, 64'd0);

    fill(6'd0,  1'b1, 20'h00010, 20'hAAAAA, 8'd1, 3'b001);
    fill(6'd5,  1'b1, 20'h00020, 20'h12345, 8'd1, 3'b011);
    fill(6'd63, 1'b1, 20'hFFFFF, 20'h00001, 8'd2, 3'b100);
    fill(6'd10, 1'b1, 20'h00030, 20'h0BEEF, 8'd3, 3'b111);
    fill(6'd20, 1'b1, 20'h00030, 20'h0CAFE, 8'd3, 3'b111);

    for (int i = 0; i < NVEC; i++) begin
      lookup(VTBL[i].va, VTBL[i].kind, VTBL[i].asid);
      chk($sformatf("R2/R4/R5/R6 table row %0d flags", i), {61'd0, flags()}, {61'd0, VTBL[i].flg});
      chk($sformatf("R3 table row %0d paddr", i), {32'd0, rsp_paddr}, {32'd0, VTBL[i].pa});
      chk($sformatf("R10 table row %0d single match", i), {63'd0, rsp_multi}, 64'd0);
    end

    // R10: duplicate translation in slots 10 and 20
    lookup(32'h00030010, 2'b01, 8'd3);
    chk("R10 lowest slot wins", {32'd0, rsp_paddr}, {32'd0, 32'h0BEEF010});
    chk("R10 multi flag", {62'd0, rsp_multi, rsp_hit}, 64'd3);

    // R7: fill and lookup in the same cycle
    fill_en = 1'b1; fill_vld = 1'b1; fill_slot = 6'd7; fill_vpn = 20'h00050;
    fill_ppn = 20'h55555; fill_asid = 8'd1; fill_perm = 3'b001;
    lookup(32'h00050444, 2'b00, 8'd1);
    fill_en = 1'b0;
    chk("R7 same-cycle lookup sees old", {61'd0, flags()}, {61'd0, F_MISS});
    lookup(32'h00050444, 2'b00, 8'd1);
    chk("R7 fill then hit", {29'd0, flags(), rsp_paddr}, {29'd0, F_HIT, 32'h55555444});

    // R8: fill with valid clear drops the slot
    fill(6'd7, 1'b0, 20'h00050, 20'h55555, 8'd1, 3'b001);
    lookup(32'h00050444, 2'b00, 8'd1);
    chk("R8 slot invalidated", {61'd0, flags()}, {61'd0, F_MISS});
    lookup(32'h00020000, 2'b00, 8'd1);
    chk("R8 other slot kept", {61'd0, flags()}, {61'd0, F_HIT});

    // R9: flush with simultaneous fill; flush wins
    flush_all = 1'b1;
    fill(6'd1, 1'b1, 20'h00060, 20'h66666, 8'd1, 3'b111);
    flush_all = 1'b0;
    lookup(32'h00010000, 2'b00, 8'd1);
    chk("R9 flushed entry misses", {61'd0, flags()}, {61'd0, F_MISS});
    lookup(32'h00060000, 2'b00, 8'd1);
    chk("R9 fill during flush dropped", {61'd0, flags()}, {61'd0, F_MISS});
    lookup(32'hFFFFF000, 2'b10, 8'd2);
    chk("R9 slot 63 flushed", {61'd0, flags()}, {61'd0, F_MISS});

    // R11: back-to-back requests then idle
    req_valid = 1'b1; req_vaddr = 32'h0; req_kind = 2'b00; req_asid = 8'd0;
    @(negedge clk);
    chk("R11 one flag per request", {61'd0, flags()}, {61'd0, F_MISS});
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11 quiet after idle", {61'd0, flags()}, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule